// File: doc/BRIEF.md
# Mirrored-Pair Cache Set Controller

This block controls a single set of a set-associative cache. The set holds two kinds of ways. Reliable ways are built from large cells that keep their contents at low supply voltage. Unreliable ways are built from small cells whose reads may be corrupted; each of these ways raises an error flag on a bad read. Where a line goes depends on the kind of miss. A line written by the core is the only copy in the system, so it lives in a reliable way, or in a pair of unreliable ways. A line that was only read also exists further down the memory hierarchy, so it lives in a single unreliable way.

The unreliable ways form fixed pairs. A write that hits a line in an unreliable way also copies the line into the other way of its pair. That other way becomes a mirror and no longer holds a line of its own. On a later read, the controller returns whichever copy has no error. A clean line with no mirror that reads back bad is fetched again from the next level. If both copies of a mirrored dirty line report an error, the controller raises an uncorrectable-error flag. The request port accepts one request at a time. A refill port and a writeback port connect to the next level of the hierarchy.

Top module: `dupway_cache_set`

## Requirements
- R1: Unreliable ways 2k and 2k+1 are partners. When a mirrored line is read and only its mirror way (not the way that holds the line) reports an error, the data comes from the way that holds the line, with hit=1 and no memory traffic.
- R2: A write that hits a line in an unreliable way stores the data in that way and in its partner. It marks the pair as mirrored and the line as dirty, and responds with hit=1 and resp_data equal to the write data.
- R3: When a partner way is taken over to become a mirror, the line it held is dropped, with a writeback if that line was dirty. Only one of the two ways of a mirrored pair can ever hit, so a later read of the dropped tag misses.
- R4: A write miss places the line, dirty, in a reliable way. The victim is the lowest-numbered invalid reliable way, or, if all are valid, the way at a reliable round-robin pointer, which then advances by one. If the victim is dirty it is written back. No refill is requested and the response has hit=0.
- R5: A read miss places the line in an unreliable way, chosen by the same rule with its own pointer (mirror ways count as valid). It raises mem_rd_req for one cycle with the tag. Once mem_rd_valid arrives, it installs the line clean and responds with hit=0 and the refilled data.
- R6: A read hit and a write hit in a reliable way leave the placement unchanged. Error flags have no effect on these hits, and they cause no memory traffic.
- R7: When the way that holds a mirrored line reports an error and its partner does not, the response carries the partner's data with hit=1.
- R8: When both ways of a mirrored pair report an error on a read of that line, resp_uncorr=1, resp_data=0 and hit=1, with no writeback and no refill request.
- R9: When a clean line with no mirror reads back with an error, it is treated as a miss. The same tag is fetched again into the same way, with no writeback, and the response has hit=0.
- R10: When a read miss picks either way of a mirrored pair as victim, the dirty line is written back once and the mirror marking is cleared. The other way keeps the line as a clean, hittable copy.
- R11: After reset all ways are invalid, req_ready=1, and resp_valid, mem_rd_req and mem_wb_valid are 0.
- R12: A response comes one cycle after the request is accepted, or one cycle after mem_rd_valid for a refill. mem_rd_req and mem_wb_valid are one-cycle pulses in the cycle after acceptance. req_ready stays low while a refill is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Line tag |
| req_wdata | input | DATA_W | Write data (whole line) |
| way_err | input | NUM_UNREL | Per unreliable way read-error flags, valid with the request |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Request hit |
| resp_uncorr | output | 1 | Both copies failed |
| resp_data | output | DATA_W | Read data or echoed write data |
| mem_rd_req | output | 1 | Refill request pulse |
| mem_rd_tag | output | TAG_W | Refill tag |
| mem_rd_valid | input | 1 | Refill data present |
| mem_rd_data | input | DATA_W | Refill data |
| mem_wb_valid | output | 1 | Writeback pulse |
| mem_wb_tag | output | TAG_W | Writeback tag |
| mem_wb_data | output | DATA_W | Writeback data |

## Verification
A stale mirror marking shows up on the next read of that line that carries an error. The controller then returns partner data that is out of date, or it drops the writeback when the pair is evicted. The writeback port exposes the second case on the eviction itself. A wrong victim pointer or wrong valid bits first appear as an unexpected refill or writeback at the next miss. Because that miss can come many requests later, the bench compares every response and every memory pulse against a reference model.

// File: rtl/dupway_pkg.sv
package dupway_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_FILL
    } st_e;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_WR_REL,
        ACT_WR_UN,
        ACT_WR_MISS,
        ACT_RD_REL,
        ACT_RD_UN,
        ACT_RD_ALT,
        ACT_RD_UNC,
        ACT_REFETCH,
        ACT_RD_MISS
    } act_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dupway_match.sv
module dupway_match #(
    parameter int N     = 4,
    parameter int TAG_W = 8,
    localparam int IW   = dupway_pkg::idx_w(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0]            excl,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            hit,
    output logic                    any,
    output logic [IW-1:0]           idx
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = valid[i] && !excl[i] && (tags[i] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) idx = IW'(i);
        end
    end

    assign any = |hit;

endmodule

// File: rtl/dupway_victim.sv
module dupway_victim #(
    parameter int N  = 4,
    localparam int IW = dupway_pkg::idx_w(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  valid,
    input  logic          take,
    output logic [IW-1:0] victim
);

    logic [IW-1:0] ptr;
    logic          found;

    always_comb begin
        victim = ptr;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !found) begin
                victim = IW'(i);
                found  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (take && !found) begin
            ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + IW'(1);
        end
    end

endmodule

// File: rtl/dupway_cache_set.sv
module dupway_cache_set
    import dupway_pkg::*;
#(
    parameter int NUM_REL   = 2,
    parameter int NUM_UNREL = 4,
    parameter int TAG_W     = 8,
    parameter int DATA_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [TAG_W-1:0]     req_tag,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [NUM_UNREL-1:0] way_err,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic                 resp_uncorr,
    output logic [DATA_W-1:0]    resp_data,
    output logic                 mem_rd_req,
    output logic [TAG_W-1:0]     mem_rd_tag,
    input  logic                 mem_rd_valid,
    input  logic [DATA_W-1:0]    mem_rd_data,
    output logic                 mem_wb_valid,
    output logic [TAG_W-1:0]     mem_wb_tag,
    output logic [DATA_W-1:0]    mem_wb_data
);

    localparam int NP  = NUM_UNREL / 2;
    localparam int RIW = idx_w(NUM_REL);
    localparam int UIW = idx_w(NUM_UNREL);
    localparam int PIW = idx_w(NP);

    // way storage
    logic [NUM_REL-1:0]                r_v, r_d;
    logic [NUM_REL-1:0][TAG_W-1:0]     r_tag;
    logic [NUM_REL-1:0][DATA_W-1:0]    r_dat;
    logic [NUM_UNREL-1:0]              u_v, u_d;
    logic [NUM_UNREL-1:0][TAG_W-1:0]   u_tag;
    logic [NUM_UNREL-1:0][DATA_W-1:0]  u_dat;
    logic [NP-1:0]                     dup, mir_odd;

    st_e              state;
    logic [UIW-1:0]   fill_way;
    logic [TAG_W-1:0] fill_tag;

    // lookup
    logic [NUM_REL-1:0]   r_hit;
    logic [NUM_UNREL-1:0] u_hit, u_excl;
    logic                 r_any, u_any;
    logic [RIW-1:0]       ri, rv;
    logic [UIW-1:0]       ui, uv, pw, vo;
    logic [PIW-1:0]       pr, vp;
    act_e                 act;

    for (genvar j = 0; j < NUM_UNREL; j++) begin : g_excl
        assign u_excl[j] = dup[j/2] && (mir_odd[j/2] == 1'(j % 2));
    end

    dupway_match #(.N(NUM_REL), .TAG_W(TAG_W)) u_rmatch (
        .valid(r_v), .excl('0), .tags(r_tag), .key(req_tag),
        .hit(r_hit), .any(r_any), .idx(ri)
    );

    dupway_match #(.N(NUM_UNREL), .TAG_W(TAG_W)) u_umatch (
        .valid(u_v), .excl(u_excl), .tags(u_tag), .key(req_tag),
        .hit(u_hit), .any(u_any), .idx(ui)
    );

    dupway_victim #(.N(NUM_REL)) u_rvict (
        .clk(clk), .rst(rst), .valid(r_v),
        .take(act == ACT_WR_MISS), .victim(rv)
    );

    dupway_victim #(.N(NUM_UNREL)) u_uvict (
        .clk(clk), .rst(rst), .valid(u_v),
        .take(act == ACT_RD_MISS), .victim(uv)
    );

    assign pw = ui ^ UIW'(1);
    assign pr = PIW'(ui >> 1);
    assign vo = uv ^ UIW'(1);
    assign vp = PIW'(uv >> 1);
    assign req_ready = (state == ST_IDLE);

    always_comb begin
        act = ACT_NONE;
        if (state == ST_IDLE && req_valid) begin
            if (req_write) begin
                if (r_any)      act = ACT_WR_REL;
                else if (u_any) act = ACT_WR_UN;
                else            act = ACT_WR_MISS;
            end else if (r_any) begin
                act = ACT_RD_REL;
            end else if (u_any) begin
                if (!way_err[ui])      act = ACT_RD_UN;
                else if (!dup[pr])     act = ACT_REFETCH;
                else if (!way_err[pw]) act = ACT_RD_ALT;
                else                   act = ACT_RD_UNC;
            end else begin
                act = ACT_RD_MISS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_v <= '0; r_d <= '0; r_tag <= '0; r_dat <= '0;
            u_v <= '0; u_d <= '0; u_tag <= '0; u_dat <= '0;
            dup <= '0; mir_odd <= '0;
            state <= ST_IDLE; fill_way <= '0; fill_tag <= '0;
            resp_valid <= 1'b0; resp_hit <= 1'b0; resp_uncorr <= 1'b0; resp_data <= '0;
            mem_rd_req <= 1'b0; mem_rd_tag <= '0;
            mem_wb_valid <= 1'b0; mem_wb_tag <= '0; mem_wb_data <= '0;
        end else begin
            resp_valid   <= 1'b0;
            resp_hit     <= 1'b0;
            resp_uncorr  <= 1'b0;
            resp_data    <= '0;
            mem_rd_req   <= 1'b0;
            mem_wb_valid <= 1'b0;
            case (act)
                ACT_WR_REL: begin
                    r_dat[ri]  <= req_wdata;
                    r_d[ri]    <= 1'b1;
                    resp_valid <= 1'b1; resp_hit <= 1'b1; resp_data <= req_wdata;
                end
                ACT_WR_UN: begin
                    if (!dup[pr]) begin
                        if (u_v[pw] && u_d[pw]) begin
                            mem_wb_valid <= 1'b1;
                            mem_wb_tag   <= u_tag[pw];
                            mem_wb_data  <= u_dat[pw];
                        end
                        dup[pr]     <= 1'b1;
                        mir_odd[pr] <= pw[0];
                    end
                    u_dat[ui] <= req_wdata; u_d[ui] <= 1'b1;
                    u_v[pw]   <= 1'b1; u_d[pw] <= 1'b1;
                    u_tag[pw] <= req_tag; u_dat[pw] <= req_wdata;
                    resp_valid <= 1'b1; resp_hit <= 1'b1; resp_data <= req_wdata;
                end
                ACT_WR_MISS: begin
                    if (r_v[rv] && r_d[rv]) begin
                        mem_wb_valid <= 1'b1;
                        mem_wb_tag   <= r_tag[rv];
                        mem_wb_data  <= r_dat[rv];
                    end
                    r_v[rv] <= 1'b1; r_d[rv] <= 1'b1;
                    r_tag[rv] <= req_tag; r_dat[rv] <= req_wdata;
                    resp_valid <= 1'b1; resp_data <= req_wdata;
                end
                ACT_RD_REL: begin
                    resp_valid <= 1'b1; resp_hit <= 1'b1; resp_data <= r_dat[ri];
                end
                ACT_RD_UN: begin
                    resp_valid <= 1'b1; resp_hit <= 1'b1; resp_data <= u_dat[ui];
                end
                ACT_RD_ALT: begin
                    resp_valid <= 1'b1; resp_hit <= 1'b1; resp_data <= u_dat[pw];
                end
                ACT_RD_UNC: begin
                    resp_valid <= 1'b1; resp_hit <= 1'b1; resp_uncorr <= 1'b1;
                end
                ACT_REFETCH: begin
                    u_v[ui]    <= 1'b0;
                    fill_way   <= ui;
                    fill_tag   <= req_tag;
                    mem_rd_req <= 1'b1;
                    mem_rd_tag <= req_tag;
                    state      <= ST_FILL;
                end
                ACT_RD_MISS: begin
                    if (dup[vp]) begin
                        mem_wb_valid <= 1'b1;
                        mem_wb_tag   <= u_tag[uv];
                        mem_wb_data  <= u_dat[uv];
                        dup[vp]      <= 1'b0;
                        u_d[vo]      <= 1'b0;
                    end else if (u_v[uv] && u_d[uv]) begin
                        mem_wb_valid <= 1'b1;
                        mem_wb_tag   <= u_tag[uv];
                        mem_wb_data  <= u_dat[uv];
                    end
                    u_v[uv]    <= 1'b0;
                    u_d[uv]    <= 1'b0;
                    fill_way   <= uv;
                    fill_tag   <= req_tag;
                    mem_rd_req <= 1'b1;
                    mem_rd_tag <= req_tag;
                    state      <= ST_FILL;
                end
                default: ;
            endcase
            if (state == ST_FILL && mem_rd_valid) begin
                u_v[fill_way]   <= 1'b1;
                u_d[fill_way]   <= 1'b0;
                u_tag[fill_way] <= fill_tag;
                u_dat[fill_way] <= mem_rd_data;
                resp_valid <= 1'b1;
                resp_data  <= mem_rd_data;
                state      <= ST_IDLE;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_UNC_QUIET: assert property (@(posedge clk) disable iff (rst)
        resp_uncorr |-> (resp_valid && resp_data == '0 && !mem_wb_valid && !mem_rd_req)); // R8

    AST_RDREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !mem_rd_req); // R12

    AST_FILL_STALL: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> !req_ready); // R12

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> $onehot0({r_hit, u_hit})); // R3

    for (genvar p = 0; p < NP; p++) begin : g_pair_chk
        AST_PAIR_MIRROR: assert property (@(posedge clk) disable iff (rst)
            dup[p] |-> (u_v[2*p] && u_v[2*p+1] && u_d[2*p] && u_d[2*p+1]
                        && u_tag[2*p] == u_tag[2*p+1] && u_dat[2*p] == u_dat[2*p+1])); // R2
    end

    for (genvar j = 0; j < NUM_UNREL; j++) begin : g_un_chk
        AST_LONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
            (u_v[j] && !dup[j/2]) |-> !u_d[j]); // R10
    end

    for (genvar i = 0; i < NUM_REL; i++) begin : g_rel_chk
        AST_REL_DIRTY: assert property (@(posedge clk) disable iff (rst)
            r_v[i] |-> r_d[i]); // R4
    end

endmodule

// File: tb/dupway_cache_set_tb.sv
`timescale 1ns/1ps
module dupway_cache_set_tb;

    localparam int NR = 2;
    localparam int NU = 4;
    localparam int NP = NU / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_tag = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  way_err = '0;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        req_ready, resp_valid, resp_hit, resp_uncorr, mem_rd_req, mem_wb_valid;
    logic [15:0] resp_data, mem_wb_data;
    logic [7:0]  mem_rd_tag, mem_wb_tag;

    always #10 clk = ~clk;

    dupway_cache_set u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_tag(req_tag), .req_wdata(req_wdata),
        .way_err(way_err), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_uncorr(resp_uncorr), .resp_data(resp_data), .mem_rd_req(mem_rd_req),
        .mem_rd_tag(mem_rd_tag), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wb_valid(mem_wb_valid), .mem_wb_tag(mem_wb_tag), .mem_wb_data(mem_wb_data)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] mem [256];
    logic        mrv [NR], mrd [NR];
    logic [7:0]  mrt [NR];
    logic [15:0] mrdat [NR];
    logic        muv [NU], mud [NU];
    logic [7:0]  mut [NU];
    logic [15:0] mudat [NU];
    logic        mdup [NP], mmodd [NP];
    int          rptr, uptr;

    // expectations for one request
    logic        e_wbv, e_rd, e_hit, e_unc;
    logic [7:0]  e_wbt, e_rdt;
    logic [15:0] e_wbd, e_dat;
    int          e_fill;
    string       e_lbl;

    task automatic chk(input string lbl, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", lbl, what, got, exp);
        end
    endtask

    function automatic logic is_mirror(input int j);
        return mdup[j/2] && (mmodd[j/2] == 1'(j % 2));
    endfunction

    task automatic pick_rel(output int v);
        v = -1;
        for (int i = 0; i < NR; i++) if (!mrv[i] && v < 0) v = i;
        if (v < 0) begin v = rptr; rptr = (rptr + 1) % NR; end
    endtask

    task automatic pick_un(output int v);
        v = -1;
        for (int i = 0; i < NU; i++) if (!muv[i] && v < 0) v = i;
        if (v < 0) begin v = uptr; uptr = (uptr + 1) % NU; end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin mrv[i] = 0; mrd[i] = 0; mrt[i] = 0; mrdat[i] = 0; end
        for (int i = 0; i < NU; i++) begin muv[i] = 0; mud[i] = 0; mut[i] = 0; mudat[i] = 0; end
        for (int i = 0; i < NP; i++) begin mdup[i] = 0; mmodd[i] = 0; end
        rptr = 0; uptr = 0;
        for (int t = 0; t < 256; t++) mem[t] = 16'(t * 16'h0107 + 16'h3c00);
    endtask

    task automatic model_req(input logic w, input logic [7:0] tag, input logic [15:0] wd, input logic [3:0] err);
        int ri, ui, v, p, pw;
        e_wbv = 0; e_rd = 0; e_hit = 0; e_unc = 0; e_dat = 0; e_wbt = 0; e_wbd = 0; e_rdt = 0;
        e_fill = -1; e_lbl = "R6";
        ri = -1; ui = -1;
        for (int i = 0; i < NR; i++) if (mrv[i] && mrt[i] == tag) ri = i;
        for (int j = 0; j < NU; j++) if (muv[j] && mut[j] == tag && !is_mirror(j)) ui = j;
        if (w) begin
            if (ri >= 0) begin
                mrdat[ri] = wd; mrd[ri] = 1; e_hit = 1; e_dat = wd; e_lbl = "R6";
            end else if (ui >= 0) begin
                p = ui / 2; pw = ui ^ 1; e_lbl = "R2";
                if (!mdup[p]) begin
                    if (muv[pw]) e_lbl = "R3";
                    if (muv[pw] && mud[pw]) begin e_wbv = 1; e_wbt = mut[pw]; e_wbd = mudat[pw]; end
                    mdup[p] = 1; mmodd[p] = 1'(pw % 2);
                end
                mudat[ui] = wd; mud[ui] = 1;
                muv[pw] = 1; mud[pw] = 1; mut[pw] = tag; mudat[pw] = wd;
                e_hit = 1; e_dat = wd;
            end else begin
                pick_rel(v); e_lbl = "R4";
                if (mrv[v] && mrd[v]) begin e_wbv = 1; e_wbt = mrt[v]; e_wbd = mrdat[v]; end
                mrv[v] = 1; mrd[v] = 1; mrt[v] = tag; mrdat[v] = wd; e_dat = wd;
            end
        end else if (ri >= 0) begin
            e_hit = 1; e_dat = mrdat[ri]; e_lbl = "R6";
        end else if (ui >= 0) begin
            p = ui / 2; pw = ui ^ 1;
            if (!err[ui]) begin
                e_hit = 1; e_dat = mudat[ui];
                e_lbl = (mdup[p] && err[pw]) ? "R1" : "R5";
            end else if (!mdup[p]) begin
                e_lbl = "R9"; muv[ui] = 0; e_rd = 1; e_rdt = tag; e_fill = ui;
            end else if (!err[pw]) begin
                e_lbl = "R7"; e_hit = 1; e_dat = mudat[pw];
            end else begin
                e_lbl = "R8"; e_hit = 1; e_unc = 1; e_dat = 0;
            end
        end else begin
            pick_un(v); p = v / 2; e_lbl = "R5";
            if (mdup[p]) begin
                e_lbl = "R10"; e_wbv = 1; e_wbt = mut[v]; e_wbd = mudat[v];
                mdup[p] = 0; mud[v ^ 1] = 0;
            end else if (muv[v] && mud[v]) begin
                e_wbv = 1; e_wbt = mut[v]; e_wbd = mudat[v];
            end
            muv[v] = 0; mud[v] = 0; e_rd = 1; e_rdt = tag; e_fill = v;
        end
    endtask

    task automatic run_req(input logic w, input logic [7:0] tag, input logic [15:0] wd, input logic [3:0] err);
        @(negedge clk);
        chk("R12", "req_ready before request", req_ready, 1'b1);
        req_valid = 1; req_write = w; req_tag = tag; req_wdata = wd; way_err = err;
        model_req(w, tag, wd, err);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; way_err = '0;
        chk(e_lbl, "mem_wb_valid", mem_wb_valid, e_wbv);
        if (e_wbv) begin
            chk(e_lbl, "mem_wb_tag", mem_wb_tag, e_wbt);
            chk(e_lbl, "mem_wb_data", mem_wb_data, e_wbd);
            mem[e_wbt] = e_wbd;
        end
        chk(e_lbl, "mem_rd_req", mem_rd_req, e_rd);
        if (e_rd) begin
            chk(e_lbl, "mem_rd_tag", mem_rd_tag, e_rdt);
            chk("R12", "req_ready during refill", req_ready, 1'b0);
            chk(e_lbl, "resp_valid before refill", resp_valid, 1'b0);
            mem_rd_valid = 1; mem_rd_data = mem[tag];
            @(posedge clk);
            @(negedge clk);
            mem_rd_valid = 0;
            muv[e_fill] = 1; mud[e_fill] = 0; mut[e_fill] = tag; mudat[e_fill] = mem[tag];
            e_dat = mem[tag]; e_hit = 0;
        end
        chk(e_lbl, "resp_valid", resp_valid, 1'b1);
        chk(e_lbl, "resp_hit", resp_hit, e_hit);
        chk(e_lbl, "resp_uncorr", resp_uncorr, e_unc);
        chk(e_lbl, "resp_data", resp_data, e_dat);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "req_ready", req_ready, 1'b1);
        chk("R11", "resp_valid", resp_valid, 1'b0);
        chk("R11", "mem_rd_req", mem_rd_req, 1'b0);
        chk("R11", "mem_wb_valid", mem_wb_valid, 1'b0);

        // directed corner cases
        run_req(0, 8'd1, 16'h0, 4'b0000);   // R5 read miss into way 0
        run_req(0, 8'd1, 16'h0, 4'b0000);   // plain hit
        run_req(1, 8'd1, 16'hA1A1, 4'b0000); // R2 mirror into way 1
        run_req(0, 8'd1, 16'h0, 4'b0001);   // R7 primary bad, partner serves
        run_req(0, 8'd1, 16'h0, 4'b0010);   // R1 mirror bad, primary serves
        run_req(0, 8'd1, 16'h0, 4'b0011);   // R8 both bad
        run_req(1, 8'd9, 16'hB9B9, 4'b0000); // R4 write miss to reliable
        run_req(0, 8'd9, 16'h0, 4'b1111);   // R6 reliable ignores errors
        run_req(0, 8'd2, 16'h0, 4'b0000);   // R5 into way 2
        run_req(0, 8'd2, 16'h0, 4'b0100);   // R9 refetch clean line
        run_req(0, 8'd3, 16'h0, 4'b0000);   // R5 into way 3
        run_req(1, 8'd2, 16'hC2C2, 4'b0000); // R3 partner way 3 taken over
        run_req(0, 8'd3, 16'h0, 4'b0000);   // R3 dropped tag misses; R10 pair evicted
        run_req(0, 8'd1, 16'h0, 4'b0000);   // survivor hit
        run_req(1, 8'd10, 16'hD0D0, 4'b0000);
        run_req(1, 8'd11, 16'hD1D1, 4'b0000); // R4 round robin with dirty writeback

        // constrained random phase
        for (int n = 0; n < 800; n++) begin
            logic        w;
            logic [7:0]  t;
            logic [15:0] d;
            logic [3:0]  e;
            w = ($urandom % 3) == 0;
            t = 8'($urandom % 10);
            d = 16'($urandom);
            e = (($urandom % 3) == 0) ? 4'($urandom) : 4'b0000;
            run_req(w, t, d, e);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule